// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 raw interrupt inputs and delivers each one to one of several parent interrupt lines on one of several cores. Every source first passes through a conditioning stage. That stage applies the per-source polarity and chooses between level detection and latched edge detection. The result is then gated by an enable mask. A per-source routing byte decides which core and which parent line the gated source reaches. All sources that land on the same core and line are ORed together into one registered output.

Software controls the block through a small 32-bit register bus with byte strobes. Enables are never written as a whole word. Software sets bits through one write-one register and clears them through another, so concurrent owners of different sources cannot undo each other's changes. The clear register also acknowledges latched edges. A status register shows which enabled sources are asserting at that moment, so a dispatcher on any core can scan it.

Top module: `irq_router`

## Requirements
- R1: After reset, all enables are 0, every routing byte is 0, every source is in level mode, the polarity register reads all ones (active-high/rising) and every output is 0.
- R2: Source s has an 8-bit routing byte at byte offset s (word offset 4*(s/4), byte lane s%4). Bits [7:4] select a parent line (bit 4+l selects line l) and bits [3:0] select a core (bit c selects core c). Each byte is written only when its byte strobe is set, and it reads back unchanged.
- R3: A write to 0x28 enables each source whose data bit is 1, and a write to 0x2C disables each source whose data bit is 1. In both cases data bits of 0, and bits in lanes whose strobe is clear, change nothing. The enable mask reads back at 0x24.
- R4: The polarity register at 0x30 works per source. In level mode a 1 means active-high and a 0 means active-low, and the source's pending state follows the adjusted input.
- R5: The status register at 0x40 shows, in bit s, whether source s is pending and enabled, with no register delay. Outputs are registered and change on the first clock edge after the cause.
- R6: A disabled source drives no output and shows 0 in status, even while its input is asserting.
- R7: Output bit c*4+l is the OR of all enabled pending sources whose routing byte has core bit c and line bit l set. A byte with several bits set drives every selected core/line pair.
- R8: When a source's bit in the mode register at 0x34 is 1, an input edge in the direction given by polarity (1 = rising, 0 = falling) sets a pending latch. The latch holds after the input returns, and writing 1 to the source's bit at 0x2C clears it.
- R9: A source whose routing byte has no line bit set, or no core bit set, drives no output, though it still shows in status.
- R10: Reads of offsets that map to no register, including the write-only 0x28 and 0x2C, return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_be | input | 4 | Byte strobes, bit j qualifies bits [8j+7:8j] |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_src | input | 32 | Raw interrupt inputs |
| irq_out | output | 16 | Parent outputs, bit core*4+line |

## Verification
The bench checks that a partial-strobe clear leaves the other byte lanes alone. A design that ignored the strobes would drop enables that software never meant to touch. It stretches an edge pulse well past its end and then clears it. A design that fed the edge straight through would drop the output early, and one that failed to clear the latch would re-assert as soon as the source was enabled again. Routing bytes with no core bit, with no line bit, and with several bits set are each tried, which catches designs that decode only the line field or allow only one target. Exact-cycle checks tell a one-cycle output register apart from a missing or doubled one.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ROUTE_W  = 8;
    localparam int LINE_LSB = 4;
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;

    // Byte offsets of the control registers
    localparam int OFF_EN_VIEW = 'h24;
    localparam int OFF_EN_SET  = 'h28;
    localparam int OFF_EN_CLR  = 'h2C;
    localparam int OFF_POL     = 'h30;
    localparam int OFF_MODE    = 'h34;
    localparam int OFF_STAT    = 'h40;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int j = 0; j < LANES; j++) begin
            m[j*8 +: 8] = {8{be[j]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_we,
    input  logic [LANES-1:0]        bus_be,
    input  logic [NSRC-1:0]         status,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [NSRC*ROUTE_W-1:0] route,
    output logic [NSRC-1:0]         en,
    output logic [NSRC-1:0]         pol,
    output logic [NSRC-1:0]         mode,
    output logic [NSRC-1:0]         clr
);

    localparam int WA_W = AW - 2;
    localparam int NRW  = (NSRC * ROUTE_W) / DATA_W;
    localparam logic [WA_W-1:0] A_VIEW = WA_W'(OFF_EN_VIEW >> 2);
    localparam logic [WA_W-1:0] A_SET  = WA_W'(OFF_EN_SET >> 2);
    localparam logic [WA_W-1:0] A_CLR  = WA_W'(OFF_EN_CLR >> 2);
    localparam logic [WA_W-1:0] A_POL  = WA_W'(OFF_POL >> 2);
    localparam logic [WA_W-1:0] A_MODE = WA_W'(OFF_MODE >> 2);
    localparam logic [WA_W-1:0] A_STAT = WA_W'(OFF_STAT >> 2);

    typedef struct packed {
        logic [NSRC*ROUTE_W-1:0] route;
        logic [NSRC-1:0]         en;
        logic [NSRC-1:0]         pol;
        logic [NSRC-1:0]         mode;
    } regs_t;

    regs_t           st_d, st_q;
    logic [WA_W-1:0] wa;
    logic [NSRC-1:0] wmask;

    assign wa    = bus_addr[AW-1:2];
    assign wmask = NSRC'(bus_wdata & lane_mask(bus_be));

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_we) begin
            for (int w = 0; w < NRW; w++) begin
                for (int j = 0; j < LANES; j++) begin
                    if (wa == WA_W'(w) && bus_be[j]) begin
                        st_d.route[(w*LANES+j)*ROUTE_W +: ROUTE_W] = bus_wdata[j*8 +: 8];
                    end
                end
            end
            case (wa)
                A_SET:   st_d.en   = st_q.en | wmask;
                A_CLR: begin
                    st_d.en = st_q.en & ~wmask;
                    clr     = wmask;
                end
                A_POL:   st_d.pol  = (st_q.pol & ~NSRC'(lane_mask(bus_be))) | wmask;
                A_MODE:  st_d.mode = (st_q.mode & ~NSRC'(lane_mask(bus_be))) | wmask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.route <= '0;
            st_q.en    <= '0;
            st_q.pol   <= '1;
            st_q.mode  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NRW; w++) begin
            if (wa == WA_W'(w)) bus_rdata = st_q.route[w*DATA_W +: DATA_W];
        end
        case (wa)
            A_VIEW:  bus_rdata = DATA_W'(st_q.en);
            A_POL:   bus_rdata = DATA_W'(st_q.pol);
            A_MODE:  bus_rdata = DATA_W'(st_q.mode);
            A_STAT:  bus_rdata = DATA_W'(status);
            default: ;
        endcase
    end

    assign route = st_q.route;
    assign en    = st_q.en;
    assign pol   = st_q.pol;
    assign mode  = st_q.mode;

endmodule

// File: rtl/irq_router_detect.sv
module irq_router_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] pol,
    input  logic [NSRC-1:0] mode,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);

    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] latch;
    } det_t;

    det_t            st_d, st_q;
    logic [NSRC-1:0] level_hit;
    logic [NSRC-1:0] edge_hit;

    always_comb begin
        level_hit  = ~(src ^ pol);
        edge_hit   = (src & ~st_q.prev & pol) | (~src & st_q.prev & ~pol);
        st_d.prev  = src;
        st_d.latch = mode & (edge_hit | (st_q.latch & ~clr));
        pend       = (mode & (st_q.latch | edge_hit)) | (~mode & level_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_router_fanout.sv
module irq_router_fanout
    import irq_router_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NLINE = 4,
    parameter int NCORE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         active,
    input  logic [NSRC*ROUTE_W-1:0] route,
    output logic [NCORE*NLINE-1:0]  irq_out
);

    localparam int NOUT = NCORE * NLINE;

    logic [NOUT-1:0] out_d, out_q;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar l = 0; l < NLINE; l++) begin : g_line
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    hit = hit | (active[s] & route[s*ROUTE_W + LINE_LSB + l]
                                           & route[s*ROUTE_W + c]);
                end
            end
            assign out_d[c*NLINE + l] = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_out = out_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NLINE = 4,
    parameter int NCORE = 4,
    parameter int AW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_we,
    input  logic [LANES-1:0]       bus_be,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NSRC-1:0]        irq_src,
    output logic [NCORE*NLINE-1:0] irq_out
);

    logic [NSRC*ROUTE_W-1:0] route_w;
    logic [NSRC-1:0]         en_w, pol_w, mode_w, clr_w, pend_w, active_w;

    assign active_w = pend_w & en_w;

    irq_router_regs #(.NSRC(NSRC), .AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .status    (active_w),
        .bus_rdata (bus_rdata),
        .route     (route_w),
        .en        (en_w),
        .pol       (pol_w),
        .mode      (mode_w),
        .clr       (clr_w)
    );

    irq_router_detect #(.NSRC(NSRC)) detect_i (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (irq_src),
        .pol   (pol_w),
        .mode  (mode_w),
        .clr   (clr_w),
        .pend  (pend_w)
    );

    irq_router_fanout #(.NSRC(NSRC), .NLINE(NLINE), .NCORE(NCORE)) fanout_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active_w),
        .route   (route_w),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NOUT = 16,
    parameter int AW   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [LANES-1:0]  bus_be,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NOUT-1:0]   irq_out,
    input logic [NSRC-1:0]   en_view
);

    localparam int WA_W = AW - 2;
    localparam int NRW  = (NSRC * ROUTE_W) / DATA_W;

    logic [WA_W-1:0] wa;
    logic [NSRC-1:0] wmask;
    logic            is_set, is_clr, mapped_rd;

    assign wa        = bus_addr[AW-1:2];
    assign wmask     = NSRC'(bus_wdata & lane_mask(bus_be));
    assign is_set    = bus_we && (wa == WA_W'(OFF_EN_SET >> 2));
    assign is_clr    = bus_we && (wa == WA_W'(OFF_EN_CLR >> 2));
    assign mapped_rd = (int'(wa) < NRW) || (wa == WA_W'(OFF_EN_VIEW >> 2)) ||
                       (wa == WA_W'(OFF_POL >> 2)) || (wa == WA_W'(OFF_MODE >> 2)) ||
                       (wa == WA_W'(OFF_STAT >> 2));

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_set |=> ((en_view & $past(wmask)) == $past(wmask)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((en_view & $past(wmask)) == '0));

    // R3
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((en_view & ~$past(wmask)) == ($past(en_view) & ~$past(wmask))));

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_view == '0) |=> (irq_out == '0));

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped_rd |-> (bus_rdata == '0));

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NOUT(NCORE*NLINE), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_view   (en_w)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_router dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .irq_src   (irq_src),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h24, v); check("R1 enable mask", v, 32'h0);
        rd(8'h00, v); check("R1 routing word 0", v, 32'h0);
        rd(8'h1C, v); check("R1 routing word 7", v, 32'h0);
        rd(8'h30, v); check("R1 polarity", v, 32'hFFFF_FFFF);
        rd(8'h34, v); check("R1 mode", v, 32'h0);
        check("R1 outputs", {16'h0, irq_out}, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        wr(8'h00, 32'h0000_2100, 4'b0010);
        rd(8'h00, v); check("R2 lane1 write", v, 32'h0000_2100);
        wr(8'h00, 32'hEEEE_EEFF, 4'b0001);
        rd(8'h00, v); check("R2 lane0 only", v, 32'h0000_21FF);
        wr(8'h00, 32'h0, 4'b0001);
        rd(8'h00, v); check("R2 lane0 cleared", v, 32'h0000_2100);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(8'h28, 32'h6, 4'b1111);
        rd(8'h24, v); check("R3 set", v, 32'h6);
        wr(8'h28, 32'h1, 4'b1111);
        rd(8'h24, v); check("R3 set keeps others", v, 32'h7);
        wr(8'h2C, 32'h4, 4'b1111);
        rd(8'h24, v); check("R3 clear one", v, 32'h3);
        wr(8'h2C, 32'hFFFF_FF03, 4'b0010);
        rd(8'h24, v); check("R3 strobe qualifies clear", v, 32'h3);
        wr(8'h2C, 32'hFFFF_FFFF, 4'b1111);
        rd(8'h24, v); check("R3 clear all", v, 32'h0);
        rd(8'h28, v); check("R10 set reg reads zero", v, 32'h0);
        rd(8'h2C, v); check("R10 clear reg reads zero", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        // src1 routed 0x21: line1 core0 -> output bit 1
        wr(8'h28, 32'h2, 4'b1111);
        @(negedge clk);
        irq_src[1] = 1'b1; bus_addr = 8'h40;
        #1;
        check("R5 status without delay", bus_rdata, 32'h2);
        check("R5 output not yet", {16'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R5 R7 output one edge later", {16'h0, irq_out}, 32'h0002);
        irq_src[1] = 1'b0;
        @(negedge clk);
        check("R4 level drops", {16'h0, irq_out}, 32'h0);
        wr(8'h30, 32'hFFFF_FFFD, 4'b1111);
        wait_n(2);
        check("R4 active low asserts", {16'h0, irq_out}, 32'h0002);
        irq_src[1] = 1'b1;
        wait_n(2);
        check("R4 active low deasserts", {16'h0, irq_out}, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF, 4'b1111);
        wr(8'h2C, 32'h2, 4'b1111);
        wait_n(2);
        check("R6 disabled no output", {16'h0, irq_out}, 32'h0);
        rd(8'h40, v); check("R6 disabled no status", v, 32'h0);
        irq_src[1] = 1'b0;
    endtask

    task automatic t_edge();
        logic [31:0] v;
        // src2 routed 0x84: line3 core2 -> output bit 11
        wr(8'h00, 32'h0084_0000, 4'b0100);
        wr(8'h34, 32'h4, 4'b1111);
        wr(8'h28, 32'h4, 4'b1111);
        @(negedge clk); irq_src[2] = 1'b1;
        @(negedge clk); irq_src[2] = 1'b0;
        @(negedge clk);
        check("R8 rising edge latched", {16'h0, irq_out}, 32'h0800);
        wait_n(3);
        check("R8 latch holds", {16'h0, irq_out}, 32'h0800);
        rd(8'h40, v); check("R8 status from latch", v, 32'h4);
        wr(8'h2C, 32'h4, 4'b1111);
        @(negedge clk);
        check("R8 clear drops output", {16'h0, irq_out}, 32'h0);
        wr(8'h28, 32'h4, 4'b1111);
        wait_n(2);
        check("R8 latch was cleared", {16'h0, irq_out}, 32'h0);
        wr(8'h30, 32'hFFFF_FFFB, 4'b1111);
        irq_src[2] = 1'b1;
        wait_n(2);
        check("R8 rise ignored when falling", {16'h0, irq_out}, 32'h0);
        irq_src[2] = 1'b0;
        wait_n(2);
        check("R8 falling edge latched", {16'h0, irq_out}, 32'h0800);
        wr(8'h2C, 32'hFFFF_FFFF, 4'b1111);
        wr(8'h30, 32'hFFFF_FFFF, 4'b1111);
        wr(8'h34, 32'h0, 4'b1111);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        wr(8'h04, 32'h0044_4400, 4'b0110);
        wr(8'h04, 32'h0100_0010, 4'b1001);
        wr(8'h28, 32'hF0, 4'b1111);
        irq_src[4] = 1'b1; irq_src[7] = 1'b1;
        wait_n(2);
        check("R9 no core or no line bit", {16'h0, irq_out}, 32'h0);
        rd(8'h40, v); check("R9 still in status", v, 32'h90);
        irq_src[4] = 1'b0; irq_src[7] = 1'b0;
        irq_src[5] = 1'b1;
        wait_n(2);
        check("R7 src5 to core2 line2", {16'h0, irq_out}, 32'h0400);
        irq_src[6] = 1'b1; irq_src[5] = 1'b0;
        wait_n(2);
        check("R7 src6 shares output", {16'h0, irq_out}, 32'h0400);
        irq_src[6] = 1'b0;
        wait_n(2);
        check("R7 OR drops", {16'h0, irq_out}, 32'h0);
        wr(8'h04, 32'h0000_3300, 4'b0010);
        irq_src[5] = 1'b1;
        wait_n(2);
        check("R7 multi-target byte", {16'h0, irq_out}, 32'h0033);
        irq_src[5] = 1'b0;
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h3C, 32'hFFFF_FFFF, 4'b1111);
        wr(8'h20, 32'hFFFF_FFFF, 4'b1111);
        rd(8'h3C, v); check("R10 read 0x3C", v, 32'h0);
        rd(8'h20, v); check("R10 read 0x20", v, 32'h0);
        rd(8'h44, v); check("R10 read 0x44", v, 32'h0);
        rd(8'h24, v); check("R10 enables untouched", v, 32'hF0);
        rd(8'h30, v); check("R10 polarity untouched", v, 32'hFFFF_FFFF);
        rd(8'h1C, v); check("R10 routing untouched", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_route();
        t_enable();
        t_level();
        t_edge();
        t_multi();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule